// File: doc/BRIEF.md
# Configurable Logic Cell Register

This block is the output cell of a programmable-logic array. One data bit comes in. It is the sum-of-products term, or a direct pin input when the cell works as a fast input register. One bit goes out. Static configuration inputs decide whether the bit passes straight through or goes through a storage element. They also set how the storage element behaves, which clock drives it, and whether the result is inverted. The configuration is expected to change only while power-up reset is held.

The storage element runs in one of three modes. In flip-flop mode it takes the data bit. In toggle mode it flips when the data bit is 1. In latch mode it is transparent while its clock is high. The clock is picked per cell from three shared global clocks or one locally generated product-term clock. A dual-edge option makes flip-flop and toggle modes act on both clock edges. This is done with one rising-edge and one falling-edge register whose outputs are chosen by the clock level, so no clock is derived inside the cell.

Three asynchronous controls override the stored value, in priority order:
- **power-up**, which loads the configured initial bit;
- **global reset**, which forces 0;
- **global preset**, which forces 1.

Seen as a state machine, each cell has a storage state (D, TOGGLE or LATCH, fixed by configuration) and a control state:
- **POWERUP** moves to RUN when `por_n` rises.
- **RUN** moves to CLEARED when `gsr_rst` rises, or to PRESET when `gsr_set` rises.
- **CLEARED** and **PRESET** return to RUN, keeping the forced value, when their control falls.

Top module: `macro_cell`

## Requirements
- R1: With `cfg_comb`=1 the output equals the selected data bit XOR `cfg_inv` at all times, whatever the clocks and the asynchronous controls are doing.
- R2: With `cfg_mode`=0 (D) and `cfg_dual`=0, the stored bit takes the data value at each rising edge of the selected clock and holds otherwise.
- R3: With `cfg_mode`=1 (toggle), the stored bit inverts at an active edge when the data bit is 1 and holds when it is 0.
- R4: With `cfg_mode`=2 (latch), the stored bit follows the data while the selected clock is high and keeps the value present at its falling edge while the clock is low. `cfg_dual` has no effect in this mode.
- R5: With `cfg_dual`=1 in D or toggle mode, both the rising and the falling edges of the selected clock are active edges.
- R6: `cfg_clk_src` values 0, 1 and 2 select `clk_glb[0]`, `clk_glb[1]` and `clk_glb[2]`, and value 3 selects `clk_pterm`. Activity on the clocks that are not selected does not change the output.
- R7: With `cfg_fast_in`=1 the data bit is `pin_in`, and with 0 it is `sop_in`.
- R8: While `gsr_rst`=1 and `por_n`=1, a registered cell outputs 0 XOR `cfg_inv` at once and ignores clock edges. It has priority over `gsr_set`. After release, the stored bit stays 0 until the next active edge.
- R9: While `gsr_set`=1 and `gsr_rst`=0 and `por_n`=1, a registered cell outputs 1 XOR `cfg_inv` and ignores clock edges.
- R10: While `por_n`=0, a registered cell outputs `cfg_init` XOR `cfg_inv`, with priority over both global controls.
- R11: `cfg_inv`=1 inverts the final output in both combinational and registered modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_glb | input | 3 | Shared global clocks |
| clk_pterm | input | 1 | Local product-term clock |
| por_n | input | 1 | Power-up initialise, active low, asynchronous |
| gsr_rst | input | 1 | Global asynchronous reset to 0 |
| gsr_set | input | 1 | Global asynchronous preset to 1 |
| sop_in | input | 1 | Sum-of-products data bit |
| pin_in | input | 1 | Direct pin data bit for fast input use |
| cfg_comb | input | 1 | 1: combinational path, 0: registered path |
| cfg_mode | input | 2 | Storage mode: 0 D, 1 toggle, 2 latch |
| cfg_clk_src | input | 2 | Clock source select (R6 encoding) |
| cfg_dual | input | 1 | Act on both clock edges |
| cfg_fast_in | input | 1 | Use pin_in as data |
| cfg_init | input | 1 | Value loaded at power-up |
| cfg_inv | input | 1 | Output polarity |
| cell_out | output | 1 | Cell output |

## Verification
All stored state reaches `cell_out` directly. A wrong bit in the rising-edge register therefore appears no later than the next time the selected clock is high. A wrong bit in the falling-edge register appears as soon as the clock is next low in dual-edge or latch mode. A toggle-mode error keeps showing at every later edge, because each new value is built from the old one. The bench checks the output once per half clock period. Any such fault is therefore seen within one check of its becoming visible. Faults in the override order show while a control is held, and faults in clock selection show at the first edge on the wrong source.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        MODE_D     = 2'd0,
        MODE_T     = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_RSVD  = 2'd3
    } st_mode_e;
endpackage

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
    parameter int N_GCLK = 3,
    parameter int SEL_W  = 2
) (
    input  logic [N_GCLK-1:0] clk_glb,
    input  logic              clk_pterm,
    input  logic [SEL_W-1:0]  sel,
    output logic              clk_o
);
    // Source indices 0..N_GCLK-1 are global; any higher index is the local clock.
    always_comb begin
        clk_o = clk_pterm;
        for (int i = 0; i < N_GCLK; i++) begin
            if (sel == SEL_W'(i)) clk_o = clk_glb[i];
        end
    end
endmodule

// File: rtl/mc_edge_ff.sv
module mc_edge_ff #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst,
    input  logic set,
    input  logic init,
    input  logic d,
    output logic q
);
    generate
        if (RISING) begin : g_pos
            always_ff @(posedge clk or negedge por_n or posedge rst or posedge set) begin
                if (!por_n)   q <= init;
                else if (rst) q <= 1'b0;
                else if (set) q <= 1'b1;
                else          q <= d;
            end
        end else begin : g_neg
            always_ff @(negedge clk or negedge por_n or posedge rst or posedge set) begin
                if (!por_n)   q <= init;
                else if (rst) q <= 1'b0;
                else if (set) q <= 1'b1;
                else          q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/macro_cell.sv
module macro_cell
    import mc_pkg::*;
#(
    parameter int N_GCLK = 3,
    localparam int SEL_W = $clog2(N_GCLK + 1)
) (
    input  logic [N_GCLK-1:0] clk_glb,
    input  logic              clk_pterm,
    input  logic              por_n,
    input  logic              gsr_rst,
    input  logic              gsr_set,
    input  logic              sop_in,
    input  logic              pin_in,
    input  logic              cfg_comb,
    input  logic [1:0]        cfg_mode,
    input  logic [SEL_W-1:0]  cfg_clk_src,
    input  logic              cfg_dual,
    input  logic              cfg_fast_in,
    input  logic              cfg_init,
    input  logic              cfg_inv,
    output logic              cell_out
);
    st_mode_e mode;
    logic     clk_s;
    logic     d_sel;
    logic     q_rise, q_fall;
    logic     nxt_rise, nxt_fall;
    logic     q_held, q_store;

    assign mode  = st_mode_e'(cfg_mode);
    assign d_sel = cfg_fast_in ? pin_in : sop_in;

    mc_clk_pick #(.N_GCLK(N_GCLK), .SEL_W(SEL_W)) u_pick (
        .clk_glb   (clk_glb),
        .clk_pterm (clk_pterm),
        .sel       (cfg_clk_src),
        .clk_o     (clk_s)
    );

    // Next-value logic per storage mode. In dual-edge toggle mode each
    // register builds on the value the other one is presenting.
    always_comb begin
        unique case (mode)
            MODE_T: begin
                nxt_rise = (cfg_dual ? q_fall : q_rise) ^ d_sel;
                nxt_fall = q_rise ^ d_sel;
            end
            default: begin
                nxt_rise = d_sel;
                nxt_fall = d_sel;
            end
        endcase
    end

    mc_edge_ff #(.RISING(1'b1)) u_rise (
        .clk   (clk_s),
        .por_n (por_n),
        .rst   (gsr_rst),
        .set   (gsr_set),
        .init  (cfg_init),
        .d     (nxt_rise),
        .q     (q_rise)
    );

    mc_edge_ff #(.RISING(1'b0)) u_fall (
        .clk   (clk_s),
        .por_n (por_n),
        .rst   (gsr_rst),
        .set   (gsr_set),
        .init  (cfg_init),
        .d     (nxt_fall),
        .q     (q_fall)
    );

    // Output selection: clock level picks the half that last captured.
    always_comb begin
        unique case (mode)
            MODE_LATCH: q_held = clk_s ? d_sel : q_fall;
            default:    q_held = (cfg_dual && !clk_s) ? q_fall : q_rise;
        endcase
    end

    // Asynchronous controls also override the transparent latch path.
    always_comb begin
        if (!por_n)       q_store = cfg_init;
        else if (gsr_rst) q_store = 1'b0;
        else if (gsr_set) q_store = 1'b1;
        else              q_store = q_held;
    end

    assign cell_out = (cfg_comb ? d_sel : q_store) ^ cfg_inv;
endmodule

// File: rtl/macro_cell_chk.sv
module macro_cell_chk (
    input logic       clk_s,
    input logic       por_n,
    input logic       gsr_rst,
    input logic       gsr_set,
    input logic       sop_in,
    input logic       pin_in,
    input logic       cfg_comb,
    input logic [1:0] cfg_mode,
    input logic       cfg_dual,
    input logic       cfg_fast_in,
    input logic       cfg_init,
    input logic       cfg_inv,
    input logic       cell_out
);
    logic data;
    logic ctl_any;
    logic clean_win = 1'b0;

    assign data    = cfg_fast_in ? pin_in : sop_in;
    assign ctl_any = !por_n || gsr_rst || gsr_set;

    // High at an edge only if no asynchronous control was seen since the previous edge.
    always_ff @(posedge clk_s or posedge ctl_any) begin
        if (ctl_any) clean_win <= 1'b0;
        else         clean_win <= 1'b1;
    end

    p_comb_path_r1: assert property (@(posedge clk_s) disable iff (!por_n)
        cfg_comb |-> (cell_out == (data ^ cfg_inv)));

    p_d_capture_r2: assert property (@(posedge clk_s) disable iff (!por_n)
        clean_win && $past(!cfg_comb && cfg_mode == 2'd0 && !cfg_dual)
        |-> (cell_out == ($past(data) ^ cfg_inv)));

    p_t_toggle_r3: assert property (@(posedge clk_s) disable iff (!por_n)
        clean_win && $past(!cfg_comb && cfg_mode == 2'd1 && !cfg_dual)
        |-> (cell_out == ($past(cell_out) ^ $past(data))));

    p_rst_force_r8: assert property (@(posedge clk_s) disable iff (!por_n)
        (gsr_rst && !cfg_comb) |-> (cell_out == cfg_inv));

    p_set_force_r9: assert property (@(posedge clk_s) disable iff (!por_n)
        (gsr_set && !gsr_rst && !cfg_comb) |-> (cell_out == !cfg_inv));

    p_powerup_r10: assert property (@(posedge clk_s) disable iff (cfg_comb)
        !por_n |-> (cell_out == (cfg_init ^ cfg_inv)));
endmodule

bind macro_cell macro_cell_chk u_chk (
    .clk_s       (clk_s),
    .por_n       (por_n),
    .gsr_rst     (gsr_rst),
    .gsr_set     (gsr_set),
    .sop_in      (sop_in),
    .pin_in      (pin_in),
    .cfg_comb    (cfg_comb),
    .cfg_mode    (cfg_mode),
    .cfg_dual    (cfg_dual),
    .cfg_fast_in (cfg_fast_in),
    .cfg_init    (cfg_init),
    .cfg_inv     (cfg_inv),
    .cell_out    (cell_out)
);

// File: tb/tb_macro_cell.sv
module tb_macro_cell;
    localparam int STEPS    = 24;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [2:0] clk_glb     = 3'b000;
    logic       clk_pterm   = 1'b0;
    logic       por_n       = 1'b0;
    logic       gsr_rst     = 1'b0;
    logic       gsr_set     = 1'b0;
    logic       sop_in      = 1'b0;
    logic       pin_in      = 1'b0;
    logic       cfg_comb    = 1'b0;
    logic [1:0] cfg_mode    = 2'd0;
    logic [1:0] cfg_clk_src = 2'd0;
    logic       cfg_dual    = 1'b0;
    logic       cfg_fast_in = 1'b0;
    logic       cfg_init    = 1'b0;
    logic       cfg_inv     = 1'b0;
    logic       cell_out;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] lfsr  = 16'hACE1;
    logic        mq    = 1'b0;   // stored bit as the requirements define it

    macro_cell dut (
        .clk_glb     (clk_glb),
        .clk_pterm   (clk_pterm),
        .por_n       (por_n),
        .gsr_rst     (gsr_rst),
        .gsr_set     (gsr_set),
        .sop_in      (sop_in),
        .pin_in      (pin_in),
        .cfg_comb    (cfg_comb),
        .cfg_mode    (cfg_mode),
        .cfg_clk_src (cfg_clk_src),
        .cfg_dual    (cfg_dual),
        .cfg_fast_in (cfg_fast_in),
        .cfg_init    (cfg_init),
        .cfg_inv     (cfg_inv),
        .cell_out    (cell_out)
    );

    // R6: source 3 is the local clock, 0..2 are the globals
    function automatic logic sel_lvl();
        return (cfg_clk_src == 2'd3) ? clk_pterm : clk_glb[cfg_clk_src];
    endfunction

    // R7: data source selection
    function automatic logic din();
        return cfg_fast_in ? pin_in : sop_in;
    endfunction

    task automatic check();
        logic  exp;
        string tag;
        if (cfg_comb) begin
            exp = din(); tag = "R1";
        end else if (!por_n) begin
            exp = cfg_init; tag = "R10";
        end else if (gsr_rst) begin
            exp = 1'b0; tag = "R8";
        end else if (gsr_set) begin
            exp = 1'b1; tag = "R9";
        end else if (cfg_mode == 2'd2 && sel_lvl()) begin
            exp = din(); tag = "R4";
        end else begin
            exp = mq;
            if (cfg_mode == 2'd2)      tag = "R4";
            else if (cfg_dual)         tag = "R5";
            else if (cfg_mode == 2'd1) tag = "R3";
            else                       tag = "R2";
        end
        exp = exp ^ cfg_inv;  // R11
        n_vec++;
        if (cell_out !== exp) begin
            n_bad++;
            $display("FAIL %s (R6 src=%0d R7 fast=%0d R11 inv=%0d mode=%0d dual=%0d): actual %b expected %b",
                     tag, cfg_clk_src, cfg_fast_in, cfg_inv, cfg_mode, cfg_dual, cell_out, exp);
        end
    endtask

    // Toggle the selected clock at the bench posedge and advance the model.
    task automatic edge_step();
        logic lvl;
        @(posedge clk);
        if (cfg_clk_src == 2'd3) clk_pterm = ~clk_pterm;
        else                     clk_glb[cfg_clk_src] = ~clk_glb[cfg_clk_src];
        lvl = sel_lvl();
        if (por_n && !gsr_rst && !gsr_set) begin
            case (cfg_mode)
                2'd2:    if (!lvl) mq = din();                 // R4 hold at fall
                2'd1:    if (lvl || cfg_dual) mq = mq ^ din(); // R3, R5
                default: if (lvl || cfg_dual) mq = din();      // R2, R5
            endcase
        end
    endtask

    // Sample, then apply new data, controls and noise on unselected clocks.
    task automatic stim_step();
        @(negedge clk);
        check();
        lfsr    = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        sop_in  = lfsr[0];
        pin_in  = lfsr[1];
        gsr_rst = (lfsr[5:3] == 3'd0);
        gsr_set = (lfsr[8:6] == 3'd0);
        for (int i = 0; i < 3; i++)
            if (cfg_clk_src != 2'(i)) clk_glb[i] = lfsr[9+i];
        if (cfg_clk_src != 2'd3) clk_pterm = lfsr[12];
        if (gsr_rst)      mq = 1'b0;
        else if (gsr_set) mq = 1'b1;
    endtask

    task automatic run_cfg(input logic c, input logic [1:0] m, input logic du,
                           input logic [1:0] s, input logic iv, input logic f,
                           input logic in);
        @(negedge clk);
        por_n = 1'b0; gsr_rst = 1'b0; gsr_set = 1'b0;
        cfg_comb = c; cfg_mode = m; cfg_dual = du; cfg_clk_src = s;
        cfg_inv = iv; cfg_fast_in = f; cfg_init = in;
        @(negedge clk);
        check();          // R10 power-up value (or R1 when combinational)
        por_n = 1'b1;
        mq    = in;
        for (int k = 0; k < STEPS; k++) begin
            edge_step();
            stim_step();
        end
    endtask

    initial begin
        for (int c = 0; c < 2; c++)
          for (int m = 0; m < 3; m++)
            for (int du = 0; du < 2; du++)
              for (int s = 0; s < 4; s++)
                for (int iv = 0; iv < 2; iv++)
                  for (int f = 0; f < 2; f++)
                    for (int in = 0; in < 2; in++)
                      run_cfg(c[0], 2'(m), du[0], 2'(s), iv[0], f[0], in[0]);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule